// File: doc/BRIEF.md
# Bank Precharge Timing Tracker

This block sits in the command path of a DDR SDRAM controller. It follows the open or closed state of every bank and decides, within the same cycle, whether the command presented on its input is allowed. Three spacing rules are enforced for each bank. A bank must stay open for at least `T_RAS` cycles after it is activated before it is precharged. A read must be followed by at least BL/2 cycles before a precharge of the same bank. A precharged bank must wait `T_RP` cycles before it is activated again. The read-to-precharge spacing is the same for every CAS latency, because CAS latency only moves the data and not the command slots.

A command that breaks a rule leaves the tracked state untouched, and a one-cycle error flag follows it. A read issued with auto-precharge makes the tracker schedule the bank's internal precharge by itself. That precharge fires at BL/2 cycles after the read, or later if the bank has not yet been open for `T_RAS` cycles. In that case it fires in the first cycle the open time is met, and the `T_RP` window counts from that cycle.

Top module: `bank_prech_tracker`

## Requirements
- R1: After reset every bank is closed, every timing window has expired and the error flag is low.
- R2: An activate (code 01) to a closed bank outside its precharge window is legal and opens that bank from the next cycle on. An activate to a bank that is already open is illegal.
- R3: A read (code 10) is legal only to an open bank with no auto-precharge pending. A read to a closed bank is illegal.
- R4: A precharge (code 11) of an open bank is illegal until `T_RAS` cycles have passed since that bank's activate.
- R5: A precharge of a bank is illegal until BL/2 cycles have passed since that bank's last read.
- R6: A precharge with the all-banks flag set is legal only if every bank meets the precharge rules, and it then closes every open bank.
- R7: An activate is illegal until `T_RP` cycles have passed since that bank's precharge began, whether the precharge was commanded or automatic.
- R8: A read with auto-precharge makes the bank's auto-precharge pulse fire for exactly one cycle, at the later of read+BL/2 and activate+`T_RAS`. The bank is closed from the following cycle.
- R9: An illegal command raises `cmd_illegal` for exactly the next cycle and changes no bank state.
- R10: A no-operation (code 00) is always legal, and all timing windows keep counting through it.
- R11: A precharge of a closed bank outside its precharge window is legal and has no effect. In particular it does not start a new precharge window.
- R12: The burst length is 2, 4 or 8, and the read-to-precharge spacing scales with it as BL/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_code | input | 2 | Command: 00 NOP, 01 ACTIVATE, 10 READ, 11 PRECHARGE |
| cmd_bank | input | BANK_W | Target bank |
| cmd_all | input | 1 | Precharge applies to all banks |
| cmd_autopre | input | 1 | Read carries auto-precharge |
| cmd_legal | output | 1 | Current command is allowed this cycle |
| cmd_illegal | output | 1 | Previous cycle's command was rejected |
| bank_open | output | 2**BANK_W | Per-bank open state |
| bank_autopre_fire | output | 2**BANK_W | Per-bank internal precharge start pulse |

## Verification
The bench goes after the auto-precharge deferral case, where a read follows its activate so closely that read+BL/2 arrives before `T_RAS`. A design that fired at BL/2 regardless would close the bank early and open the `T_RP` window too soon. It sweeps read and precharge offsets around every window edge for burst lengths 4 and 8, so an off-by-one counter shows up as a legality mismatch in a single cycle. Precharges of closed banks and all-bank precharges with one bank still busy are also covered. A tracker that restarted `T_RP` for an idle bank would reject the activate that follows, and one that checked only the addressed bank would close a bank that is still inside its window.

// File: rtl/bpt_pkg.sv
`timescale 1ns/1ps
package bpt_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_ACT  = 2'b01,
    CMD_READ = 2'b10,
    CMD_PRE  = 2'b11
  } cmd_e;

  // Read-to-precharge spacing in clocks for a given burst length.
  function automatic int unsigned read_to_pre(input int unsigned burst);
    return burst / 2;
  endfunction

  function automatic bit burst_supported(input int unsigned burst);
    return (burst == 2) || (burst == 4) || (burst == 8);
  endfunction

  // Width of a down-counter loaded with (window - 1).
  function automatic int unsigned window_width(input int unsigned window);
    return (window < 2) ? 1 : $clog2(window);
  endfunction

endpackage

// File: rtl/bpt_bank_timer.sv
`timescale 1ns/1ps
module bpt_bank_timer #(
  parameter int unsigned T_RAS = 6,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RTP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_go,
  input  logic read_go,
  input  logic read_ap,
  input  logic pre_go,
  output logic is_open,
  output logic ras_ok,
  output logic rtp_ok,
  output logic rp_ok,
  output logic ap_pend,
  output logic ap_fire,
  output logic prech_start
);
  localparam int unsigned RAS_W = bpt_pkg::window_width(T_RAS);
  localparam int unsigned RP_W  = bpt_pkg::window_width(T_RP);
  localparam int unsigned RTP_W = bpt_pkg::window_width(T_RTP);
  localparam logic [RAS_W-1:0] RAS_LOAD = RAS_W'(T_RAS - 1);
  localparam logic [RP_W-1:0]  RP_LOAD  = RP_W'(T_RP - 1);
  localparam logic [RTP_W-1:0] RTP_LOAD = RTP_W'(T_RTP - 1);

  logic [RAS_W-1:0] ras_left;
  logic [RP_W-1:0]  rp_left;
  logic [RTP_W-1:0] rtp_left;

  assign ras_ok = (ras_left == '0);
  assign rp_ok  = (rp_left == '0);
  assign rtp_ok = (rtp_left == '0);

  // Deferred auto-precharge: waits for both the read spacing and tRAS.
  assign ap_fire     = ap_pend & ras_ok & rtp_ok;
  assign prech_start = pre_go | ap_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_left <= '0;
      rp_left  <= '0;
      rtp_left <= '0;
      is_open  <= 1'b0;
      ap_pend  <= 1'b0;
    end else begin
      if (act_go)
        ras_left <= RAS_LOAD;
      else if (!ras_ok)
        ras_left <= ras_left - 1'b1;

      if (read_go)
        rtp_left <= RTP_LOAD;
      else if (!rtp_ok)
        rtp_left <= rtp_left - 1'b1;

      if (prech_start)
        rp_left <= RP_LOAD;
      else if (!rp_ok)
        rp_left <= rp_left - 1'b1;

      if (prech_start)
        is_open <= 1'b0;
      else if (act_go)
        is_open <= 1'b1;

      if (prech_start)
        ap_pend <= 1'b0;
      else if (read_go)
        ap_pend <= read_ap;
    end
  end
endmodule

// File: rtl/bpt_cmd_gate.sv
`timescale 1ns/1ps
module bpt_cmd_gate #(
  parameter int unsigned BANK_W = 2,
  localparam int unsigned NBANK = 1 << BANK_W
) (
  input  bpt_pkg::cmd_e     cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic              all_banks,
  input  logic [NBANK-1:0]  is_open,
  input  logic [NBANK-1:0]  ras_ok,
  input  logic [NBANK-1:0]  rtp_ok,
  input  logic [NBANK-1:0]  rp_ok,
  input  logic [NBANK-1:0]  ap_pend,
  output logic              legal,
  output logic [NBANK-1:0]  act_go,
  output logic [NBANK-1:0]  read_go,
  output logic [NBANK-1:0]  pre_go
);
  logic [NBANK-1:0] sel;
  logic [NBANK-1:0] pre_ok;
  logic [NBANK-1:0] pre_mask;

  // A bank may be precharged when outside tRP, with no pending auto-precharge,
  // and either idle or past both its tRAS and read spacing.
  for (genvar b = 0; b < NBANK; b++) begin : g_preok
    assign pre_ok[b] = rp_ok[b] & ~ap_pend[b] & (~is_open[b] | (ras_ok[b] & rtp_ok[b]));
  end

  always_comb begin
    sel       = '0;
    sel[bank] = 1'b1;
    pre_mask  = all_banks ? '1 : sel;
    legal     = 1'b1;
    act_go    = '0;
    read_go   = '0;
    pre_go    = '0;
    case (cmd)
      bpt_pkg::CMD_ACT: begin
        legal  = |(sel & ~is_open & rp_ok);
        act_go = legal ? sel : '0;
      end
      bpt_pkg::CMD_READ: begin
        legal   = |(sel & is_open & ~ap_pend);
        read_go = legal ? sel : '0;
      end
      bpt_pkg::CMD_PRE: begin
        legal  = all_banks ? (&pre_ok) : (|(sel & pre_ok));
        pre_go = legal ? (pre_mask & is_open) : '0;
      end
      default: legal = 1'b1;
    endcase
  end
endmodule

// File: rtl/bank_prech_tracker.sv
`timescale 1ns/1ps
module bank_prech_tracker #(
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_RP      = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cmd_code,
  input  logic [BANK_W-1:0]        cmd_bank,
  input  logic                     cmd_all,
  input  logic                     cmd_autopre,
  output logic                     cmd_legal,
  output logic                     cmd_illegal,
  output logic [(1<<BANK_W)-1:0]   bank_open,
  output logic [(1<<BANK_W)-1:0]   bank_autopre_fire
);
  localparam int unsigned NBANK = 1 << BANK_W;
  localparam int unsigned T_RTP = bpt_pkg::read_to_pre(BURST_LEN);

  if (!bpt_pkg::burst_supported(BURST_LEN)) begin : g_bad_burst
    $error("bank_prech_tracker: BURST_LEN must be 2, 4 or 8");
  end
  if (T_RAS < 1 || T_RP < 1) begin : g_bad_timing
    $error("bank_prech_tracker: T_RAS and T_RP must be at least 1");
  end

  bpt_pkg::cmd_e    cmd;
  logic [NBANK-1:0] is_open, ras_ok, rtp_ok, rp_ok, ap_pend;
  logic [NBANK-1:0] act_go, read_go, pre_go, ap_fire, prech_start;

  assign cmd = bpt_pkg::cmd_e'(cmd_code);

  bpt_cmd_gate #(.BANK_W(BANK_W)) gate_i (
    .cmd       (cmd),
    .bank      (cmd_bank),
    .all_banks (cmd_all),
    .is_open   (is_open),
    .ras_ok    (ras_ok),
    .rtp_ok    (rtp_ok),
    .rp_ok     (rp_ok),
    .ap_pend   (ap_pend),
    .legal     (cmd_legal),
    .act_go    (act_go),
    .read_go   (read_go),
    .pre_go    (pre_go)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bpt_bank_timer #(.T_RAS(T_RAS), .T_RP(T_RP), .T_RTP(T_RTP)) timer_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_go      (act_go[b]),
      .read_go     (read_go[b]),
      .read_ap     (cmd_autopre),
      .pre_go      (pre_go[b]),
      .is_open     (is_open[b]),
      .ras_ok      (ras_ok[b]),
      .rtp_ok      (rtp_ok[b]),
      .rp_ok       (rp_ok[b]),
      .ap_pend     (ap_pend[b]),
      .ap_fire     (ap_fire[b]),
      .prech_start (prech_start[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_illegal <= 1'b0;
    else        cmd_illegal <= ~cmd_legal;
  end

  assign bank_open         = is_open;
  assign bank_autopre_fire = ap_fire;
endmodule

// File: rtl/bpt_chk.sv
`timescale 1ns/1ps
module bpt_chk #(
  parameter int unsigned NBANK = 4,
  parameter int unsigned T_RAS = 6,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RTP = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd_code,
  input logic             cmd_all,
  input logic             cmd_legal,
  input logic             cmd_illegal,
  input logic [NBANK-1:0] bank_open,
  input logic [NBANK-1:0] act_go,
  input logic [NBANK-1:0] read_go,
  input logic [NBANK-1:0] prech_start,
  input logic [NBANK-1:0] ap_fire
);
  localparam int unsigned MAXW = (T_RAS > T_RP) ? ((T_RAS > T_RTP) ? T_RAS : T_RTP)
                                                : ((T_RP > T_RTP) ? T_RP : T_RTP);
  localparam int unsigned LIM = MAXW + 1;
  localparam int unsigned CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] SAT = CW'(LIM);

  for (genvar b = 0; b < NBANK; b++) begin : g_b
    logic [CW-1:0] since_act, since_read, since_pre;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        since_act  <= SAT;
        since_read <= SAT;
        since_pre  <= SAT;
      end else begin
        since_act  <= act_go[b]      ? CW'(1) : (since_act  == SAT ? SAT : since_act  + 1'b1);
        since_read <= read_go[b]     ? CW'(1) : (since_read == SAT ? SAT : since_read + 1'b1);
        since_pre  <= prech_start[b] ? CW'(1) : (since_pre  == SAT ? SAT : since_pre  + 1'b1);
      end
    end

    a_r7_act_after_rp: assert property (@(posedge clk) disable iff (!rst_n)
      act_go[b] |-> since_pre >= CW'(T_RP));
    a_r4_pre_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
      prech_start[b] |-> since_act >= CW'(T_RAS));
    a_r5_pre_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      prech_start[b] |-> since_read >= CW'(T_RTP));
    a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
      act_go[b] |=> bank_open[b]);
    a_r3_read_open: assert property (@(posedge clk) disable iff (!rst_n)
      read_go[b] |-> bank_open[b]);
    a_r8_ap_single: assert property (@(posedge clk) disable iff (!rst_n)
      ap_fire[b] |=> (!bank_open[b] && !ap_fire[b]));
  end

  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_legal |=> cmd_illegal);
  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_legal |=> !cmd_illegal);
  a_r9_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_legal && ap_fire == '0) |=> $stable(bank_open));
  a_r10_nop_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code == 2'b00 |-> cmd_legal);
  a_r6_all_close: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 2'b11 && cmd_all && cmd_legal) |=> bank_open == '0);
endmodule

bind bank_prech_tracker bpt_chk #(
  .NBANK (NBANK),
  .T_RAS (T_RAS),
  .T_RP  (T_RP),
  .T_RTP (T_RTP)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_code    (cmd_code),
  .cmd_all     (cmd_all),
  .cmd_legal   (cmd_legal),
  .cmd_illegal (cmd_illegal),
  .bank_open   (bank_open),
  .act_go      (act_go),
  .read_go     (read_go),
  .prech_start (prech_start),
  .ap_fire     (ap_fire)
);

// File: tb/bank_prech_tracker_tb_top.sv
`timescale 1ns/1ps
module bank_prech_tracker_tb_top;
  localparam int NB   = 4;
  localparam int TRAS = 6;
  localparam int TRP  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cmd_code = 2'b00;
  logic [1:0] cmd_bank = 2'b00;
  logic cmd_all = 1'b0;
  logic cmd_autopre = 1'b0;

  logic        legal_v [2];
  logic        ill_v   [2];
  logic [NB-1:0] open_v [2];
  logic [NB-1:0] fire_v [2];

  always #4 clk = ~clk;

  bank_prech_tracker #(.BANK_W(2), .BURST_LEN(4), .T_RAS(TRAS), .T_RP(TRP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_all(cmd_all), .cmd_autopre(cmd_autopre), .cmd_legal(legal_v[0]),
    .cmd_illegal(ill_v[0]), .bank_open(open_v[0]), .bank_autopre_fire(fire_v[0]));

  bank_prech_tracker #(.BANK_W(2), .BURST_LEN(8), .T_RAS(TRAS), .T_RP(TRP)) dut8_i (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_all(cmd_all), .cmd_autopre(cmd_autopre), .cmd_legal(legal_v[1]),
    .cmd_illegal(ill_v[1]), .bank_open(open_v[1]), .bank_autopre_fire(fire_v[1]));

  int checks = 0;
  int fails  = 0;
  int now    = 0;
  int rtp_c [2] = '{2, 4};
  bit m_open [2][NB];
  bit m_ap   [2][NB];
  int t_act  [2][NB];
  int t_rd   [2][NB];
  int t_pre  [2][NB];
  bit exp_ill [2];
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, now);
    end
  endtask

  function automatic bit ras_met(int c, int b); return now - t_act[c][b] >= TRAS; endfunction
  function automatic bit rtp_met(int c, int b); return now - t_rd[c][b] >= rtp_c[c]; endfunction
  function automatic bit rp_met(int c, int b);  return now - t_pre[c][b] >= TRP; endfunction

  function automatic bit pre_allowed(int c, int b);
    if (!rp_met(c, b) || m_ap[c][b]) return 1'b0;
    return !m_open[c][b] || (ras_met(c, b) && rtp_met(c, b));
  endfunction

  function automatic bit model_legal(int c, int op, int b, bit al);
    case (op)
      1: return !m_open[c][b] && rp_met(c, b);
      2: return m_open[c][b] && !m_ap[c][b];
      3: begin
        if (al) begin
          for (int k = 0; k < NB; k++) if (!pre_allowed(c, k)) return 1'b0;
          return 1'b1;
        end
        return pre_allowed(c, b);
      end
      default: return 1'b1;
    endcase
  endfunction

  function automatic string legal_tag(int c, int op, int b, bit al);
    if (c == 1) return "R12";
    case (op)
      1: return m_open[c][b] ? "R2" : "R7";
      2: return "R3";
      3: if (al) return "R6";
         else if (!m_open[c][b]) return "R11";
         else if (ras_met(c, b)) return "R5";
         else return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      exp_ill[c] = 1'b0;
      for (int b = 0; b < NB; b++) begin
        m_open[c][b] = 1'b0; m_ap[c][b] = 1'b0;
        t_act[c][b] = -1000; t_rd[c][b] = -1000; t_pre[c][b] = -1000;
      end
    end
  endtask

  task automatic step(input int op, input int b, input bit al, input bit ap);
    @(negedge clk);
    cmd_code = 2'(op); cmd_bank = 2'(b); cmd_all = al; cmd_autopre = ap;
    #1;
    for (int c = 0; c < 2; c++) begin
      bit lg;
      logic [NB-1:0] ef, eo;
      lg = model_legal(c, op, b, al);
      for (int k = 0; k < NB; k++) begin
        ef[k] = m_ap[c][k] && ras_met(c, k) && rtp_met(c, k);
        eo[k] = m_open[c][k];
      end
      chk(legal_v[c] == lg, legal_tag(c, op, b, al), int'(legal_v[c]), int'(lg));
      chk(open_v[c] == eo, "R2 open", int'(open_v[c]), int'(eo));
      chk(fire_v[c] == ef, "R8 autopre", int'(fire_v[c]), int'(ef));
      chk(ill_v[c] == exp_ill[c], "R9 flag", int'(ill_v[c]), int'(exp_ill[c]));
      // advance model to next cycle
      for (int k = 0; k < NB; k++)
        if (ef[k]) begin m_open[c][k] = 1'b0; m_ap[c][k] = 1'b0; t_pre[c][k] = now; end
      if (lg) begin
        if (op == 1) begin m_open[c][b] = 1'b1; t_act[c][b] = now; end
        if (op == 2) begin t_rd[c][b] = now; m_ap[c][b] = ap; end
        if (op == 3)
          for (int k = 0; k < NB; k++)
            if ((al || k == b) && m_open[c][k]) begin m_open[c][k] = 1'b0; t_pre[c][k] = now; end
      end
      exp_ill[c] = !lg;
    end
    now++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 1'b0, 1'b0);
  endtask

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    for (int c = 0; c < 2; c++) begin
      chk(open_v[c] == '0, "R1 open", int'(open_v[c]), 0);
      chk(ill_v[c] == 1'b0, "R1 flag", int'(ill_v[c]), 0);
      chk(fire_v[c] == '0, "R1 fire", int'(fire_v[c]), 0);
    end

    // R8: auto-precharge deferred by tRAS
    step(1, 0, 0, 0); step(2, 0, 0, 1); idle(10);
    // R8: auto-precharge at BL/2 once tRAS met
    step(1, 1, 0, 0); idle(6); step(2, 1, 0, 1); idle(8);
    // R11: precharge of an idle bank, then immediate activate
    step(3, 2, 0, 0); step(1, 2, 0, 0); step(3, 2, 0, 0); idle(8);
    // R3: read of closed bank; R2: double activate
    step(2, 3, 0, 0); step(1, 3, 0, 0); step(1, 3, 0, 0);
    // R6: all-bank precharge while bank 3 is young, then when met
    step(3, 0, 1, 0); idle(7); step(3, 0, 1, 0); step(1, 3, 0, 0); idle(3);

    // Sweep: activate, read at offset a, precharge at offset d after read
    for (int ap = 0; ap < 2; ap++)
      for (int a = 1; a <= 7; a++)
        for (int d = 0; d <= 5; d++) begin
          idle(12); step(3, 0, 1, 0); idle(4);
          step(1, 0, 0, 0);
          idle(a - 1);
          step(2, 0, 0, ap[0]);
          idle(d);
          step(3, 0, 0, 0);
          step(1, 0, 0, 0);
          idle(TRP - 1);
          step(1, 0, 0, 0);
        end

    // Pseudo-random mixed stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(int'(lfsr[1:0]), int'(lfsr[3:2]), lfsr[6:4] == 3'b000, lfsr[7]);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule